// File: doc/BRIEF.md
# SDRAM Refresh and Initialization Sequencer

This block drives the housekeeping side of a small SDRAM controller. When enable rises, it first counts down a long programmable settling time, so that supplies and the memory clock can stabilise. It then issues the power-up commands to the command encoder, one strobe per command: precharge of all banks, one auto-refresh, then a mode-register load. A programmable gap of 1 to 8 idle cycles separates these steps.

Once the mode register is loaded, the block raises `ready` and starts a refresh timer. The refresh period is programmable in clock cycles. Each time the period expires, one refresh becomes due and goes into a small saturating pending counter. The access arbiter sees `ref_req` while refreshes are pending. A pending refresh is issued as a one-cycle strobe in any cycle where the arbiter's `busy` input is low. Refreshes that fall due while the counter is full are lost, and a sticky flag records this. Dropping enable returns the block to idle, and the full delay and power-up sequence must then run again.

Top module: `sdram_hk_seq`

## Requirements
- R1: While `rst` is high, and in every cycle after a clock edge that sampled `en` low, all of `cmd_pre`, `cmd_ref`, `cmd_lmr`, `ready` and `ref_req` are 0, `pend_cnt` is 0 and `overflow` is 0.
- R2: Number the rising edges from the first edge that samples `en` high as edge 1, with `en` held high after it. `cmd_pre` is then high in the cycle right after edge D+2, where D is `init_delay`. It is not high earlier.
- R3: `cmd_ref` is high G+2 cycles after `cmd_pre`, and `cmd_lmr` is high G+2 cycles after that refresh, where G is `step_gap` (0..7, giving G+1 idle cycles between steps). The `busy` input does not delay any of these three power-up commands.
- R4: `ready` rises in the cycle after the `cmd_lmr` strobe and stays high while `en` stays high.
- R5: At most one of the three command strobes is high in any cycle. `cmd_pre` and `cmd_lmr` are each high for exactly one cycle per power-up.
- R6: Number the cycles with `ready` high from 0, and let P be a nonzero `refresh_period`. A refresh then falls due at the end of cycles P-1, 2P-1, 3P-1 and so on. With `busy` held low, `cmd_ref` is high exactly in cycles P, 2P, 3P and so on.
- R7: While `ready` is high, `cmd_ref` is high exactly when `pend_cnt` is nonzero and `busy` is low, in that same cycle. `ref_req` is high exactly when `ready` is high and `pend_cnt` is nonzero.
- R8: `pend_cnt` (binary) rises by 1 after a cycle in which a refresh fell due and none was issued. It falls by 1 after a cycle in which one was issued and none fell due. Otherwise it is unchanged. It never exceeds 4.
- R9: A refresh that falls due while `pend_cnt` is 4 and none is issued is discarded, and `overflow` goes high. `overflow` then stays high until `en` drops or reset.
- R10: With `refresh_period` equal to 0, no refresh falls due: `pend_cnt` stays 0 and `cmd_ref` stays low after power-up.
- R11: Dropping `en` at any point, in the middle of the delay or while running, clears the pending count and the flag. The next rise of `en` repeats the full delay and power-up sequence with the timing of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the doubled-rate peripheral clock) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low holds the block idle |
| refresh_period | input | 10 | Refresh interval in cycles; 0 disables periodic refresh |
| init_delay | input | 14 | Settling delay before power-up commands |
| step_gap | input | 3 | Idle cycles between power-up steps, minus one |
| busy | input | 1 | Arbiter busy with a data access; blocks refresh issue |
| cmd_pre | output | 1 | Precharge-all command strobe |
| cmd_ref | output | 1 | Auto-refresh command strobe |
| cmd_lmr | output | 1 | Load-mode-register command strobe |
| ready | output | 1 | Power-up complete, periodic refresh active |
| ref_req | output | 1 | At least one refresh pending |
| pend_cnt | output | 3 | Number of pending refreshes |
| overflow | output | 1 | Sticky: a due refresh was discarded |

## Verification
The power-up timing is swept over a grid of settling delays, including zero, and step gaps, including the extremes 0 and 7. One power-up runs with `busy` held high, which confirms that arbitration never gates the power-up commands. The running phase is tried with five `busy` patterns. All-low isolates the refresh schedule. A long busy burst fills the counter, saturates it and sets the flag. Every-third-cycle and pseudo-random patterns exercise a due refresh and an issued one landing in the same cycle. A late burst shows the backlog draining one per free cycle. Periods of 1, 2, 4, 7 and 0 cover back-to-back refreshes and the disabled case. Enable is dropped both in mid-delay and while running, to confirm that the backlog is cleared and the full sequence restarts.

// File: rtl/sdram_hk_pkg.sv
package sdram_hk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_GAP1,
        ST_IREF,
        ST_GAP2,
        ST_LMR,
        ST_RUN
    } hk_state_e;

    typedef struct packed {
        logic prech;
        logic arf;
        logic lmr;
    } hk_cmd_t;

    function automatic logic is_gap(input hk_state_e s);
        return (s == ST_GAP1) || (s == ST_GAP2);
    endfunction

    function automatic hk_state_e gap_exit(input hk_state_e s);
        return (s == ST_GAP1) ? ST_IREF : ST_LMR;
    endfunction

endpackage

// File: rtl/hk_step_timer.sv
module hk_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hk_period_timer.sv
module hk_period_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] period,
    output logic         due
);
    logic [W-1:0] cnt;
    logic         active;

    assign active = run && (period != '0);
    assign due    = active && (cnt >= (period - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (due) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hk_pend_ctr.sv
module hk_pend_ctr #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          due,
    input  logic          issue_ok,
    output logic [CW-1:0] count,
    output logic          issue,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    assign issue = issue_ok && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (due && !issue) begin
            if (count == FULL) begin
                ovf <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end else if (!due && issue) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/hk_sequencer.sv
module hk_sequencer
    import sdram_hk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      init_done,
    input  logic      gap_done,
    output hk_state_e state
);
    hk_state_e nxt;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_WAIT;
                ST_WAIT: if (init_done) nxt = ST_PRE;
                ST_PRE:  nxt = ST_GAP1;
                ST_GAP1,
                ST_GAP2: if (gap_done) nxt = gap_exit(state);
                ST_IREF: nxt = ST_GAP2;
                ST_LMR:  nxt = ST_RUN;
                ST_RUN:  nxt = ST_RUN;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/sdram_hk_seq.sv
module sdram_hk_seq
    import sdram_hk_pkg::*;
#(
    parameter  int PER_W    = 10,
    parameter  int DLY_W    = 14,
    parameter  int GAP_W    = 3,
    parameter  int PEND_MAX = 4,
    localparam int CNT_W    = $clog2(PEND_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] refresh_period,
    input  logic [DLY_W-1:0] init_delay,
    input  logic [GAP_W-1:0] step_gap,
    input  logic             busy,
    output logic             cmd_pre,
    output logic             cmd_ref,
    output logic             cmd_lmr,
    output logic             ready,
    output logic             ref_req,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             overflow
);
    hk_state_e state;
    hk_cmd_t   cmd;
    logic      init_done;
    logic      gap_done;
    logic      run;
    logic      due;
    logic      issue;

    hk_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .init_done (init_done),
        .gap_done  (gap_done),
        .state     (state)
    );

    hk_step_timer #(.W(DLY_W)) u_init_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (state != ST_WAIT),
        .limit (init_delay),
        .done  (init_done)
    );

    hk_step_timer #(.W(GAP_W)) u_gap_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (!is_gap(state)),
        .limit (step_gap),
        .done  (gap_done)
    );

    assign run = en && (state == ST_RUN);

    hk_period_timer #(.W(PER_W)) u_per_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .period (refresh_period),
        .due    (due)
    );

    hk_pend_ctr #(.DEPTH(PEND_MAX), .CW(CNT_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .clear    (!run),
        .due      (due),
        .issue_ok (run && !busy),
        .count    (pend_cnt),
        .issue    (issue),
        .ovf      (overflow)
    );

    always_comb begin
        cmd.prech = en && (state == ST_PRE);
        cmd.arf   = (en && (state == ST_IREF)) || issue;
        cmd.lmr   = en && (state == ST_LMR);
    end

    assign cmd_pre = cmd.prech;
    assign cmd_ref = cmd.arf;
    assign cmd_lmr = cmd.lmr;
    assign ready   = run;
    assign ref_req = run && (pend_cnt != '0);
endmodule

// File: rtl/hk_seq_chk.sv
module hk_seq_chk #(
    parameter int PEND_MAX = 4,
    parameter int CW       = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          busy,
    input logic          cmd_pre,
    input logic          cmd_ref,
    input logic          cmd_lmr,
    input logic          ready,
    input logic          ref_req,
    input logic [CW-1:0] pend_cnt,
    input logic          overflow
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ready && !ref_req && !cmd_pre && !cmd_lmr && !cmd_ref
                 && pend_cnt == '0 && !overflow)); // R1

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_pre, cmd_ref, cmd_lmr})); // R5

    AST_PRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_pre |=> !cmd_pre); // R5

    AST_LMR_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_lmr |=> !cmd_lmr); // R5

    AST_LMR_READY: assert property (@(posedge clk) disable iff (rst)
        cmd_lmr |=> (ready || !en)); // R4

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ready |=> (ready || !en)); // R4

    AST_NO_REF_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ready && busy) |-> !cmd_ref); // R7

    AST_NO_REF_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ready && pend_cnt == '0) |-> !cmd_ref); // R7

    AST_REQ_READY: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> ready); // R7

    AST_PEND_MAX: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CW'(PEND_MAX)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && en) |=> overflow); // R9
endmodule

bind sdram_hk_seq hk_seq_chk #(.PEND_MAX(PEND_MAX), .CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .busy     (busy),
    .cmd_pre  (cmd_pre),
    .cmd_ref  (cmd_ref),
    .cmd_lmr  (cmd_lmr),
    .ready    (ready),
    .ref_req  (ref_req),
    .pend_cnt (pend_cnt),
    .overflow (overflow)
);

// File: tb/sim_sdram_hk_seq.sv
module sim_sdram_hk_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [9:0]  refresh_period;
    logic [13:0] init_delay;
    logic [2:0]  step_gap;
    logic        busy;
    logic        cmd_pre, cmd_ref, cmd_lmr, ready, ref_req, overflow;
    logic [2:0]  pend_cnt;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdram_hk_seq u0 (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .refresh_period (refresh_period),
        .init_delay     (init_delay),
        .step_gap       (step_gap),
        .busy           (busy),
        .cmd_pre        (cmd_pre),
        .cmd_ref        (cmd_ref),
        .cmd_lmr        (cmd_lmr),
        .ready          (ready),
        .ref_req        (ref_req),
        .pend_cnt       (pend_cnt),
        .overflow       (overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_quiet(input string req);
        chk(!cmd_pre && !cmd_ref && !cmd_lmr, req, {cmd_pre, cmd_ref, cmd_lmr}, 0);
        chk(!ready && !ref_req, req, {ready, ref_req}, 0);
        chk(pend_cnt == 0 && !overflow, req, {pend_cnt, overflow}, 0);
    endtask

    function automatic bit pat(input int p, input int r);
        case (p)
            0:       return 1'b0;
            1:       return r < 30;
            2:       return (r % 3) != 0;
            3:       return ((r * 7) >> 2) & 1;
            default: return (r >= 10) && (r < 45);
        endcase
    endfunction

    // Raise enable and time the power-up strobes (R2, R3, R4, R5).
    task automatic do_init(input int d, input int g, input bit b);
        int t_pre = -1, t_ref = -1, t_lmr = -1, t_rdy = -1;
        int n_pre = 0, n_lmr = 0;
        en = 1'b0;
        busy = b;
        init_delay = 14'(d);
        step_gap = 3'(g);
        cyc();
        cyc();
        en = 1'b1;
        for (int n = 1; n <= d + 2 * g + 20; n++) begin
            cyc();
            chk($countones({cmd_pre, cmd_ref, cmd_lmr}) <= 1, "R5",
                $countones({cmd_pre, cmd_ref, cmd_lmr}), 1);
            if (cmd_pre) begin n_pre++; if (t_pre < 0) t_pre = n; end
            if (cmd_lmr) begin n_lmr++; if (t_lmr < 0) t_lmr = n; end
            if (cmd_ref && t_ref < 0) t_ref = n;
            if (ready) begin t_rdy = n; break; end
        end
        chk(t_pre == d + 2, "R2", t_pre, d + 2);
        chk(t_ref == d + g + 4, "R3", t_ref, d + g + 4);
        chk(t_lmr == d + 2 * g + 6, "R3", t_lmr, d + 2 * g + 6);
        chk(t_rdy == d + 2 * g + 7, "R4", t_rdy, d + 2 * g + 7);
        chk(n_pre == 1 && n_lmr == 1, "R5", n_pre + n_lmr, 2);
    endtask

    // Cycle model of the running phase; r = 0 is the first ready cycle.
    task automatic run_model(input int p, input int pt, input int len);
        int  pend = 0;
        bit  ovf = 1'b0;
        refresh_period = 10'(p);
        for (int r = 0; r < len; r++) begin
            bit b, strobe, due_now;
            if (r > 0) cyc();
            b = pat(pt, r);
            busy = b;
            #1;
            strobe  = (pend > 0) && !b;
            due_now = (p != 0) && ((r % p) == p - 1);
            chk(ready == 1'b1, "R4", ready, 1);
            // R6 schedule when busy is always low, R10 when the period is zero
            chk(cmd_ref == strobe, (p == 0) ? "R10" : ((pt == 0) ? "R6" : "R7"),
                cmd_ref, strobe);
            chk(ref_req == (pend > 0), "R7", ref_req, pend > 0);
            chk(pend_cnt == pend, "R8", pend_cnt, pend);
            chk(overflow == ovf, "R9", overflow, ovf);
            if (due_now && !strobe) begin
                if (pend == 4) ovf = 1'b1;
                else pend++;
            end else if (!due_now && strobe) begin
                pend--;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int periods[5] = '{1, 2, 4, 7, 0};
        int dlys[4]    = '{0, 1, 6, 37};
        rst = 1'b1;
        en = 1'b0;
        busy = 1'b0;
        refresh_period = 10'd4;
        init_delay = 14'd3;
        step_gap = 3'd1;
        cyc();
        chk_quiet("R1");
        cyc();
        cyc();
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk_quiet("R1");
        end

        // Sweep delay and gap, each followed by a run pattern.
        for (int di = 0; di < 4; di++) begin
            for (int gi = 0; gi < 3; gi++) begin
                int g = (gi == 0) ? 0 : ((gi == 1) ? 2 : 7);
                int k = di * 3 + gi;
                do_init(dlys[di], g, (k == 4));
                run_model(periods[k % 5], k % 5, 60);
            end
        end

        // Saturation and overflow, then disable while running (R9, R11).
        do_init(2, 1, 1'b0);
        run_model(2, 1, 50);
        chk(overflow == 1'b1, "R9", overflow, 1);
        en = 1'b0;
        cyc();
        chk_quiet("R11");
        cyc();
        chk_quiet("R1");

        // Disable in the middle of the delay, then restart (R11).
        init_delay = 14'd20;
        en = 1'b1;
        for (int i = 0; i < 5; i++) cyc();
        chk(!cmd_pre && !ready, "R11", cmd_pre, 0);
        en = 1'b0;
        cyc();
        chk_quiet("R11");
        do_init(20, 3, 1'b0);
        run_model(3, 0, 30);

        summary();
    end
endmodule